// File: doc/BRIEF.md
# Loss-of-Signal Interrupt Status Logic

This block tracks a receive loss-of-signal condition on one framer channel. It brings the raw condition into the local clock domain and compares it with its previous value. It records any change, whether the signal is lost or restored, in a sticky status bit. While both a per-source enable and a block-level enable are set, the sticky bit drives a registered, active-high interrupt request.

A small register port gives access to four byte-wide registers: an interrupt control register, a block enable register, the status register and a source enable register. The interrupt control register selects how the status bit is cleared. In one mode a read of the status register clears it. In the other mode a write-one-to-clear is needed. If a new change of state arrives in the same cycle as a clear, the new change wins.

Top module: `los_irq_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00 and the interrupt output is low.
- R2: A low-to-high change of the loss-of-signal input sets status bit 4 at offset 0x02. The bit is visible on reads three clock edges after the input changes.
- R3: A high-to-low change of the loss-of-signal input also sets status bit 4 at offset 0x02.
- R4: The interrupt output is high exactly one cycle after the status bit, the source enable and the block enable are all one.
- R5: When the source enable (bit 4 at offset 0x03) is 0, a set status bit does not raise the interrupt.
- R6: When the block enable (bit 1 at offset 0x01) is 0, a set status bit does not raise the interrupt.
- R7: When the clear-on-read select (bit 0 at offset 0x00) is 1, a read of offset 0x02 returns the current status and clears the bit. Writes to offset 0x02 have no effect in this mode.
- R8: When the clear-on-read select is 0, writing 1 to bit 4 of offset 0x02 clears the status bit. Writing 0 to that bit, or reading the register, leaves it unchanged.
- R9: If a change of loss-of-signal state and a clear fall in the same cycle, the status bit ends up set.
- R10: The control bits read back at their stated positions. All other bits read as 0, and offsets above 0x03 read 0x00.
- R11: While the loss-of-signal input stays steady and no clear occurs, the status bit holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| los_raw | input | 1 | Asynchronous loss-of-signal condition |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_rd | input | 1 | Read strobe, sampled on the clock edge for clear-on-read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Registered active-high interrupt request |

## Verification
The bench builds the block with its defaults: two synchronizer stages and a four-bit register offset. With two stages, the bench can check the three-edge delay from the input to the status bit and line up a write-one-to-clear with the exact cycle in which a change is detected. With a four-bit offset, the bench can reach the unmapped offsets 0x04 to 0x0F and check that they read as zero.

// File: rtl/los_irq_pkg.sv
package los_irq_pkg;
    localparam int unsigned REG_W      = 8;
    // register offsets
    localparam int unsigned OFS_CTRL   = 0;
    localparam int unsigned OFS_BLK_EN = 1;
    localparam int unsigned OFS_STAT   = 2;
    localparam int unsigned OFS_SRC_EN = 3;
    // bit positions within the registers
    localparam int unsigned BIT_RUR    = 0;
    localparam int unsigned BIT_BLK    = 1;
    localparam int unsigned BIT_LOS    = 4;

    typedef struct packed {
        logic rur_sel;
        logic blk_en;
        logic src_en;
        logic irq;
    } ctrl_t;

    typedef struct packed {
        logic prev;
        logic status;
    } det_t;
endpackage

// File: rtl/los_irq_sync.sv
module los_irq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

    // R2: the first stage follows the raw input one edge later
    a_r2_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> chain_q[0] == $past(d));
endmodule

// File: rtl/los_irq_status.sv
module los_irq_status
    import los_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic los_sync,
    input  logic clr,
    output logic change,
    output logic status
);
    det_t st_d, st_q;

    always_comb begin
        change       = los_sync ^ st_q.prev;
        st_d.prev    = los_sync;
        // a new change outranks a clear in the same cycle
        st_d.status  = (st_q.status & ~clr) | change;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;

    a_r2_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> status);
    a_r3_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.prev == $past(los_sync));
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (change && clr) |=> status);
    a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !change) |=> !status);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!change && !clr) |=> $stable(status));
endmodule

// File: rtl/los_irq_regs.sv
module los_irq_regs
    import los_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [REG_W-1:0]  wdata,
    input  logic              status,
    output logic [REG_W-1:0]  rdata,
    output logic              clr,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_BLK  = ADDR_W'(OFS_BLK_EN);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFS_SRC_EN);

    ctrl_t r_d, r_q;
    logic  hit_stat;
    logic  unused_wdata_bits;

    assign unused_wdata_bits = ^wdata;

    always_comb begin
        r_d      = r_q;
        hit_stat = (addr == A_STAT);
        if (wr && addr == A_CTRL) r_d.rur_sel = wdata[BIT_RUR];
        if (wr && addr == A_BLK)  r_d.blk_en  = wdata[BIT_BLK];
        if (wr && addr == A_SRC)  r_d.src_en  = wdata[BIT_LOS];
        clr      = hit_stat && (r_q.rur_sel ? rd : (wr && wdata[BIT_LOS]));
        r_d.irq  = status && r_q.src_en && r_q.blk_en;

        rdata = '0;
        unique case (addr)
            A_CTRL:  rdata[BIT_RUR] = r_q.rur_sel;
            A_BLK:   rdata[BIT_BLK] = r_q.blk_en;
            A_STAT:  rdata[BIT_LOS] = status;
            A_SRC:   rdata[BIT_LOS] = r_q.src_en;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq = r_q.irq;

    a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(status && r_q.src_en && r_q.blk_en));
    a_r5_src_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.src_en |=> !irq);
    a_r6_blk_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.blk_en |=> !irq);
    a_r7_rur_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.rur_sel && rd && hit_stat) |-> clr);
    a_r10_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CTRL) |=> r_q.rur_sel == $past(wdata[BIT_RUR]));
endmodule

// File: rtl/los_irq_top.sv
module los_irq_top
    import los_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              los_raw,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    logic los_sync;
    logic los_change;
    logic los_status;
    logic los_clr;

    los_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (los_raw),
        .q     (los_sync)
    );

    los_irq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .los_sync (los_sync),
        .clr      (los_clr),
        .change   (los_change),
        .status   (los_status)
    );

    los_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .wdata  (reg_wdata),
        .status (los_status),
        .rdata  (reg_rdata),
        .clr    (los_clr),
        .irq    (irq)
    );

    // R1: nothing is pending or requested in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq && !los_status));
endmodule

// File: tb/test_los_irq_top.sv
module test_los_irq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       los_raw = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [3:0] addr;
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t sb[$];

    always #5 clk = ~clk;

    los_irq_top #(.SYNC_STAGES(2), .ADDR_W(4)) i_los_irq_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .los_raw   (los_raw),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // monitor: compare read data mid-cycle against the scoreboard
    always @(negedge clk) begin
        if (reg_rd) begin
            rd_item_t it;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expectation actual=%02h expected=none", reg_rdata);
            end else begin
                it = sb.pop_front();
                if (reg_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: addr %0h actual=%02h expected=%02h", it.tag, it.addr, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        @(posedge clk); #2;
        it.addr = a; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #2;
        reg_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s: irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    task automatic drive_los(input logic v);
        @(posedge clk); #2;
        los_raw = v;
        repeat (6) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        chk_irq(1'b0, "R1 irq after reset");
        for (int a = 0; a < 4; a++) rd_reg(4'(a), 8'h00, "R1 register reset value");

        // R10: read-back positions and unmapped offsets
        rd_reg(4'h5, 8'h00, "R10 unmapped offset");
        wr_reg(4'h0, 8'hFF); rd_reg(4'h0, 8'h01, "R10 control readback");
        wr_reg(4'h1, 8'hFF); rd_reg(4'h1, 8'h02, "R10 block enable readback");
        wr_reg(4'h3, 8'hFF); rd_reg(4'h3, 8'h10, "R10 source enable readback");
        wr_reg(4'hF, 8'hFF); rd_reg(4'hF, 8'h00, "R10 unmapped write ignored");
        wr_reg(4'h0, 8'h00); wr_reg(4'h1, 8'h00); wr_reg(4'h3, 8'h00);
        rd_reg(4'h2, 8'h00, "R11 status clear with steady input");

        // R2: rising change sets status; reads do not clear in write-to-clear mode
        drive_los(1'b1);
        rd_reg(4'h2, 8'h10, "R2 rising change sets status");
        rd_reg(4'h2, 8'h10, "R8 read leaves status in write-to-clear mode");
        chk_irq(1'b0, "R5 R6 both enables off");

        // R6, R5, R4: enable gating
        wr_reg(4'h3, 8'h10); repeat (2) @(posedge clk);
        chk_irq(1'b0, "R6 block enable off masks");
        wr_reg(4'h3, 8'h00); wr_reg(4'h1, 8'h02); repeat (2) @(posedge clk);
        chk_irq(1'b0, "R5 source enable off masks");
        wr_reg(4'h3, 8'h10); repeat (2) @(posedge clk);
        chk_irq(1'b1, "R4 both enables on");

        // R8: write-one-to-clear
        wr_reg(4'h2, 8'hEF);
        rd_reg(4'h2, 8'h10, "R8 writing 0 to bit 4 has no effect");
        wr_reg(4'h2, 8'h10);
        rd_reg(4'h2, 8'h00, "R8 writing 1 to bit 4 clears");
        chk_irq(1'b0, "R4 irq drops after clear");

        // R11: steady input keeps status clear
        repeat (10) @(posedge clk);
        rd_reg(4'h2, 8'h00, "R11 no spurious set");

        // R3: falling change sets status
        drive_los(1'b0);
        rd_reg(4'h2, 8'h10, "R3 falling change sets status");
        chk_irq(1'b1, "R4 irq on falling change");

        // R7: clear-on-read mode
        wr_reg(4'h0, 8'h01);
        wr_reg(4'h2, 8'h10);
        rd_reg(4'h2, 8'h10, "R7 write ignored, read returns status");
        rd_reg(4'h2, 8'h00, "R7 read cleared status");
        repeat (2) @(posedge clk);
        chk_irq(1'b0, "R7 irq gone after read clear");

        // R9: change and clear in the same cycle
        wr_reg(4'h0, 8'h00);
        drive_los(1'b1);
        rd_reg(4'h2, 8'h10, "R9 status set before collision");
        @(posedge clk); #2 los_raw = 1'b0;   // change detected after second edge
        @(posedge clk);
        @(posedge clk); #2;
        reg_addr = 4'h2; reg_wdata = 8'h10; reg_wr = 1'b1;
        @(posedge clk); #2 reg_wr = 1'b0;
        rd_reg(4'h2, 8'h10, "R9 set wins over clear");
        wr_reg(4'h2, 8'h10);
        rd_reg(4'h2, 8'h00, "R8 clear after collision");

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule